// File: doc/BRIEF.md
# Interrupt Priority Target Selector

This block picks, for one interrupt target, the interrupt that should be offered next. It takes a vector of pending bits, a per-source enable vector, a packed array of per-source priorities and the target's threshold. It returns the identifier of the winning source and a request line to the target. Each source's identifier is its bit position in the vectors. Identifier 0 means "no interrupt", so bit 0 never takes part in selection.

Selection runs through a balanced reduction tree of priority/identifier pairs. The claim identifier does not depend on the threshold. The request line rises only when the winner's priority is strictly above the threshold. Both outputs are registered. A system with several targets uses one instance per target.

Top module: `irq_target_select`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it, win_id_o is 0 and req_o is 0.
- R2: Both outputs reflect the inputs sampled at the previous rising clock edge, so they change one cycle after the inputs change.
- R3: A source takes part in selection only when its pend_i bit and its enable_i bit are both 1.
- R4: Among the sources that take part, win_id_o is the one with the numerically largest priority.
- R5: When several sources that take part share the largest priority, the lowest identifier wins.
- R6: Bit 0 of pend_i and enable_i never takes part in selection, so identifier 0 is never chosen for it.
- R7: When no source takes part, win_id_o is 0 and req_o is 0.
- R8: win_id_o does not depend on thresh_i. A winner whose priority is at or below the threshold is still presented.
- R9: req_o is 1 exactly when a winner exists and its priority is strictly greater than thresh_i. Equal values give 0.
- R10: A winner with priority 0 never raises req_o. A threshold equal to MAXPRIO suppresses req_o for every source.
- R11: Source i takes its priority from prio_i[i*PW +: PW], where PW = $clog2(MAXPRIO+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | NSRC | Pending bit per source |
| enable_i | input | NSRC | Per-source enable for this target |
| prio_i | input | NSRC*PW | Packed priorities, source i in field i |
| thresh_i | input | PW | Target threshold |
| win_id_o | output | $clog2(NSRC) | Registered identifier of the winner, 0 for none |
| req_o | output | 1 | Registered request to the target |

## Verification
A bad compare node in the tree shows up as a wrong identifier on win_id_o one clock after the inputs that exercise that node. The identifier is then either a lower-priority source, the higher of two tied identifiers, or a source that is not enabled. A wrong threshold compare shows up on req_o in the same cycle: a spurious request when the priority equals the threshold, or a missing one when it is just above. The vector table places winners on both sides of each tree level, and it sets the threshold at, just below and above the winner's priority.

// File: rtl/irq_target_select.sv
module irq_target_select #(
  parameter int NSRC    = 32,
  parameter int MAXPRIO = 7,
  localparam int PW     = $clog2(MAXPRIO + 1),
  localparam int IDW    = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pend_i,
  input  logic [NSRC-1:0]   enable_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic [PW-1:0]     thresh_i,
  output logic [IDW-1:0]    win_id_o,
  output logic              req_o
);

  localparam int LEAVES = 1 << $clog2(NSRC);
  localparam int NODES  = 2 * LEAVES;

  logic           nv [1:NODES-1];
  logic [PW-1:0]  np [1:NODES-1];
  logic [IDW-1:0] ni [1:NODES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NSRC) begin : g_real
      assign nv[LEAVES+i] = (i != 0) && pend_i[i] && enable_i[i];
      assign np[LEAVES+i] = prio_i[i*PW +: PW];
      assign ni[LEAVES+i] = IDW'(i);
    end else begin : g_pad
      assign nv[LEAVES+i] = 1'b0;
      assign np[LEAVES+i] = '0;
      assign ni[LEAVES+i] = '0;
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+1] && (!nv[2*k] || (np[2*k+1] > np[2*k]));
    assign nv[k]  = nv[2*k] || nv[2*k+1];
    assign np[k]  = take_r ? np[2*k+1] : np[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_id_o <= '0;
      req_o    <= 1'b0;
    end else begin
      win_id_o <= nv[1] ? ni[1] : '0;
      req_o    <= nv[1] && (np[1] > thresh_i);
    end
  end

endmodule

// File: rtl/irq_target_select_chk.sv
module irq_target_select_chk #(
  parameter int NSRC    = 32,
  parameter int MAXPRIO = 7,
  localparam int PW     = $clog2(MAXPRIO + 1),
  localparam int IDW    = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   pend_i,
  input logic [NSRC-1:0]   enable_i,
  input logic [NSRC*PW-1:0] prio_i,
  input logic [PW-1:0]     thresh_i,
  input logic [IDW-1:0]    win_id_o,
  input logic              req_o
);

  logic [NSRC-1:0]    elig_q;
  logic [NSRC*PW-1:0] prio_q;
  logic [PW-1:0]      thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q <= '0;
      prio_q <= '0;
      thr_q  <= '0;
    end else begin
      elig_q <= pend_i & enable_i;
      prio_q <= prio_i;
      thr_q  <= thresh_i;
    end
  end

  logic [PW-1:0] win_prio;
  logic          better_exists;
  logic          any_elig;

  assign win_prio = prio_q[win_id_o*PW +: PW];

  always_comb begin
    better_exists = 1'b0;
    any_elig      = 1'b0;
    for (int j = 1; j < NSRC; j++) begin
      if (elig_q[j]) begin
        any_elig = 1'b1;
        if (prio_q[j*PW +: PW] > win_prio) better_exists = 1'b1;
        if (prio_q[j*PW +: PW] == win_prio && j < int'(win_id_o)) better_exists = 1'b1;
      end
    end
  end

  assert_winner_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id_o != '0) |-> elig_q[win_id_o]);

  assert_no_better_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id_o != '0) |-> !better_exists);

  assert_none_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |-> (win_id_o == '0 && !req_o));

  assert_found_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |-> (win_id_o != '0));

  assert_req_above_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (win_id_o != '0 && win_prio > thr_q));

  assert_req_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id_o != '0 && win_prio > thr_q) |-> req_o);

  assert_prio_zero_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_prio == '0) |-> !req_o);

endmodule

bind irq_target_select irq_target_select_chk #(.NSRC(NSRC), .MAXPRIO(MAXPRIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .enable_i(enable_i),
  .prio_i(prio_i), .thresh_i(thresh_i), .win_id_o(win_id_o), .req_o(req_o)
);

// File: tb/irq_target_select_tb.sv
module irq_target_select_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int MAXPRIO = 7;
  localparam int PW = 3;
  localparam int IDW = 3;

  typedef struct packed {
    logic [7:0]  pend;
    logic [7:0]  en;
    logic [23:0] pr;
    logic [2:0]  thr;
    logic [2:0]  id;
    logic        req;
  } vec_t;

  // PA: s1=7 s2=6 s3=5 s4=4 s5=3 s6=2 s7=1 ; PB: all 5 ; PC: only s0=7 ; PD: s6=6
  localparam logic [23:0] PA = 24'h29CBBF;
  localparam logic [23:0] PB = 24'hB6DB6D;
  localparam logic [23:0] PC = 24'h000007;
  localparam logic [23:0] PD = 24'h180000;
  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{8'hFF, 8'hFF, PA, 3'd0, 3'd1, 1'b1},  // R4
    '{8'hFE, 8'h7C, PA, 3'd0, 3'd2, 1'b1},  // R3
    '{8'h0F, 8'hF0, PA, 3'd0, 3'd0, 1'b0},  // R7
    '{8'hFF, 8'hFF, PB, 3'd4, 3'd1, 1'b1},  // R5
    '{8'hFF, 8'hFF, PB, 3'd5, 3'd1, 1'b0},  // R9 equal
    '{8'hA0, 8'hFF, PB, 3'd0, 3'd5, 1'b1},  // R5
    '{8'h01, 8'h01, PC, 3'd0, 3'd0, 1'b0},  // R6
    '{8'h03, 8'h03, PC, 3'd0, 3'd1, 1'b0},  // R10 prio 0
    '{8'hFF, 8'hFF, PA, 3'd7, 3'd1, 1'b0},  // R10 max threshold
    '{8'h80, 8'h80, PA, 3'd3, 3'd7, 1'b0},  // R8
    '{8'h80, 8'h80, PA, 3'd0, 3'd7, 1'b1},  // R8
    '{8'h30, 8'hFF, PA, 3'd3, 3'd4, 1'b1},  // R4
    '{8'h48, 8'hFF, PD, 3'd0, 3'd6, 1'b1}   // R11
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] pend_i = '0;
  logic [NSRC-1:0] enable_i = '0;
  logic [NSRC*PW-1:0] prio_i = '0;
  logic [PW-1:0] thresh_i = '0;
  logic [IDW-1:0] win_id_o;
  logic req_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_target_select #(.NSRC(NSRC), .MAXPRIO(MAXPRIO)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .enable_i(enable_i),
    .prio_i(prio_i), .thresh_i(thresh_i), .win_id_o(win_id_o), .req_o(req_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    pend_i = v.pend; enable_i = v.en; prio_i = v.pr; thresh_i = v.thr;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    apply(TBL[0]);
    #(CLK_PERIOD*2 + 2);
    check("R1 id in reset", int'(win_id_o), 0);
    check("R1 req in reset", int'(req_o), 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) apply(TBL[i]);
      @(negedge clk);
      check($sformatf("R3-R11 vec%0d id", i), int'(win_id_o), int'(TBL[i].id));
      check($sformatf("vec%0d req", i), int'(req_o), int'(TBL[i].req));
    end

    // R2: one-cycle latency
    @(negedge clk) apply(TBL[2]);
    @(negedge clk) apply(TBL[3]);
    #1;
    check("R2 before edge id", int'(win_id_o), 0);
    @(posedge clk); #1;
    check("R2 after edge id", int'(win_id_o), 1);
    check("R2 after edge req", int'(req_o), 1);

    // R8: threshold sweep leaves the identifier unchanged
    for (int t = 0; t < 8; t++) begin
      @(negedge clk) begin apply(TBL[0]); thresh_i = 3'(t); end
      @(negedge clk);
      check($sformatf("R8 thr%0d id", t), int'(win_id_o), 1);
      check($sformatf("R9 thr%0d req", t), int'(req_o), (t < 7) ? 1 : 0);
    end

    // R1: reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #2;
    check("R1 mid reset id", int'(win_id_o), 0);
    check("R1 mid reset req", int'(req_o), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R2 post reset id", int'(win_id_o), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule